// File: doc/BRIEF.md
# UART Hex Command to AXI4 Bridge

This block turns lines of ASCII text into AXI4 burst transfers of 16-bit words. Bytes come from a UART receiver as a valid/ready stream. A line that starts with `w` carries a hex start address followed by hex data words, and the bridge writes those words as one burst. A line that starts with `r` carries a hex start address and a hex value equal to the burst length minus one, and the bridge reads that burst. The words it reads go back as ASCII hex text on a second valid/ready byte stream toward a UART transmitter.

Write data words are held in an internal store until the line terminator arrives, so the burst length is known before the address request goes out. A malformed line is dropped as a whole and produces no bus traffic. Only one command runs at a time. `rx_ready` stays low from the terminator of an accepted line until that command is complete. For a write, that is the write-response handshake. For a read, it is the last text byte being accepted.

Back-pressure rules:
- On the receive stream, a byte is consumed in a cycle where `rx_valid` and `rx_ready` are both high.
- On the transmit stream, `tx_data` holds steady while `tx_valid` is high and `tx_ready` is low.
- On the AXI side, every valid signal, with its payload, holds until its ready.
- `rready` is raised only when the text formatter is free. A read-data stall therefore propagates back to the AXI slave.

Top module: `hex_cmd_axi_bridge`

## Requirements
- R1: A line `w<addr> <d0> <d1> ...` terminated by CR (0x0D) or LF (0x0A) produces one write burst with awaddr equal to the address and awlen equal to the word count minus one. W beats then carry the words in typed order, with wlast on the final beat only.
- R2: A line `r<addr> <n>` terminated by CR or LF produces one read request with araddr equal to the address and arlen equal to n (low 8 bits).
- R3: Hex fields are zero-extended: an address with fewer digits than ADDR_W/4 fills the low bits, and a data word with fewer than 4 digits fills the low bits of the 16-bit word.
- R4: Each read word is sent as 4 lowercase hex digits, most significant first. It is followed by a space (0x20), or by CR then LF for the word that arrives with rlast.
- R5: Hex digits 0-9, a-f and A-F are all accepted, and a run of several spaces between fields counts as one separator.
- R6: A line containing any character other than hex digits, space, CR, LF and the leading `w`/`r` is discarded up to its terminator, with no bus transfer. So is a write line with no data word, a read line without a length, and a read line with more than one field after the address. Empty lines are ignored.
- R7: A write line with up to MAX_WORDS words (awlen up to 255) is executed. A line with more words is discarded without a bus transfer.
- R8: From the terminator of an accepted line until the command completes, rx_ready is low. Completion is the B handshake for a write, or acceptance of the final LF for a read.
- R9: awvalid and arvalid hold with stable address and length until their ready, and tx_valid holds with stable tx_data until tx_ready.
- R10: During and right after reset, rx_ready is high and tx_valid, awvalid, wvalid, arvalid are low.
- R11: A read beat is accepted only while no text byte is pending (rready implies tx_valid low), and each accepted beat starts text on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Bridge can take a byte |
| rx_data | input | 8 | Received ASCII byte |
| tx_valid | output | 1 | Text byte present |
| tx_ready | input | 1 | Transmitter takes the byte |
| tx_data | output | 8 | ASCII byte to send |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | ADDR_W | Write start byte address |
| awlen | output | 8 | Write beats minus one |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wlast | output | 1 | Final write beat |
| wdata | output | 16 | Write data word |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| araddr | output | ADDR_W | Read start byte address |
| arlen | output | 8 | Read beats minus one |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| rlast | input | 1 | Final read beat |
| rdata | input | 16 | Read data word |

## Verification
Write lines cover short and long bursts, including a full 256-word burst. Each is read back with requests whose length is given in hex, so any error in word order, word count or wlast placement shows up as wrong text. Lines with uppercase digits, repeated spaces and short fields separate the character decoder and zero-extension from the main parser. Malformed, empty-field, extra-field and 257-word lines are each followed by a read of the targeted region, which shows that no data reached memory. The AXI slave and the text sink both stall in shifting patterns, so holding rules and the blocking of new input are tested against back-pressure on every channel.

// File: rtl/hcab_pkg.sv
package hcab_pkg;

  localparam logic [7:0] CH_SPACE = 8'h20;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_LF    = 8'h0A;
  localparam logic [7:0] CH_WR    = 8'h77;
  localparam logic [7:0] CH_RD    = 8'h72;

  typedef enum logic [2:0] {
    PS_CMD, PS_ADDR, PS_FIELD, PS_SKIP, PS_EXEC
  } pstate_t;

  typedef enum logic [2:0] {
    ES_IDLE, ES_AW, ES_W, ES_B, ES_AR, ES_R, ES_DRAIN, ES_FIN
  } estate_t;

  typedef struct packed {
    logic       hex;
    logic       space;
    logic       eol;
    logic       wr;
    logic       rd;
    logic [3:0] val;
  } char_t;

  function automatic char_t classify(input logic [7:0] c);
    char_t r;
    r = '0;
    if (c >= 8'h30 && c <= 8'h39) begin
      r.hex = 1'b1; r.val = 4'(c - 8'h30);
    end else if (c >= 8'h61 && c <= 8'h66) begin
      r.hex = 1'b1; r.val = 4'(c - 8'h57);
    end else if (c >= 8'h41 && c <= 8'h46) begin
      r.hex = 1'b1; r.val = 4'(c - 8'h37);
    end
    r.space = (c == CH_SPACE);
    r.eol   = (c == CH_CR) || (c == CH_LF);
    r.wr    = (c == CH_WR);
    r.rd    = (c == CH_RD);
    return r;
  endfunction

  function automatic logic [7:0] nib2asc(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h57 + {4'h0, n});
  endfunction

endpackage

// File: rtl/hcab_line_parser.sv
module hcab_line_parser
  import hcab_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int MAX_WORDS = 256,
  parameter int CNT_W     = $clog2(MAX_WORDS + 1),
  parameter int IDX_W     = $clog2(MAX_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  input  logic              done,
  output logic              go,
  output logic              is_rd,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  nwords,
  output logic [7:0]        rdlen,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [15:0]       rd_word
);

  pstate_t           st;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       field_q;
  logic              fdig_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              have_len_q;
  logic [7:0]        rdlen_q;
  logic [15:0]       store [MAX_WORDS];

  char_t            ch;
  logic             take, commit, full, commit_err, len_next, line_ok;
  logic [CNT_W-1:0] cnt_next;

  assign ch         = classify(rx_data);
  assign rx_ready   = (st != PS_EXEC);
  assign take       = rx_valid && rx_ready;
  assign commit     = (st == PS_FIELD) && fdig_q && (ch.space || ch.eol);
  assign full       = (cnt_q == CNT_W'(MAX_WORDS));
  assign commit_err = commit && (rd_q ? have_len_q : full);
  assign cnt_next   = cnt_q + CNT_W'(commit && !rd_q);
  assign len_next   = have_len_q || (commit && rd_q);
  assign line_ok    = rd_q ? len_next : (cnt_next != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= PS_CMD;
      rd_q       <= 1'b0;
      addr_q     <= '0;
      field_q    <= '0;
      fdig_q     <= 1'b0;
      cnt_q      <= '0;
      have_len_q <= 1'b0;
      rdlen_q    <= '0;
    end else begin
      case (st)
        PS_CMD: if (take) begin
          if (ch.wr || ch.rd) begin
            st         <= PS_ADDR;
            rd_q       <= ch.rd;
            addr_q     <= '0;
            field_q    <= '0;
            fdig_q     <= 1'b0;
            cnt_q      <= '0;
            have_len_q <= 1'b0;
          end else if (!ch.eol) begin
            st <= PS_SKIP;
          end
        end
        PS_ADDR: if (take) begin
          if (ch.hex)        addr_q <= {addr_q[ADDR_W-5:0], ch.val};
          else if (ch.space) st <= PS_FIELD;
          else if (ch.eol)   st <= PS_CMD;
          else               st <= PS_SKIP;
        end
        PS_FIELD: if (take) begin
          if (ch.hex) begin
            field_q <= {field_q[11:0], ch.val};
            fdig_q  <= 1'b1;
          end else if (ch.space || ch.eol) begin
            if (commit_err) begin
              st <= ch.eol ? PS_CMD : PS_SKIP;
            end else begin
              if (commit) begin
                field_q <= '0;
                fdig_q  <= 1'b0;
                if (rd_q) begin
                  rdlen_q    <= field_q[7:0];
                  have_len_q <= 1'b1;
                end else begin
                  cnt_q <= cnt_next;
                end
              end
              if (ch.eol) st <= line_ok ? PS_EXEC : PS_CMD;
            end
          end else begin
            st <= PS_SKIP;
          end
        end
        PS_SKIP: if (take && ch.eol) st <= PS_CMD;
        PS_EXEC: if (done) st <= PS_CMD;
        default: st <= PS_CMD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take && commit && !commit_err && !rd_q)
      store[cnt_q[IDX_W-1:0]] <= field_q;
  end

  assign go      = (st == PS_EXEC);
  assign is_rd   = rd_q;
  assign addr    = addr_q;
  assign nwords  = cnt_q;
  assign rdlen   = rdlen_q;
  assign rd_word = store[rd_idx];

endmodule

// File: rtl/hcab_burst_engine.sv
module hcab_burst_engine
  import hcab_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int CNT_W  = 9,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              is_rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  nwords,
  input  logic [7:0]        rdlen,
  output logic              done,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [15:0]       word,
  output logic              awvalid,
  input  logic              awready,
  output logic [ADDR_W-1:0] awaddr,
  output logic [7:0]        awlen,
  output logic              wvalid,
  input  logic              wready,
  output logic              wlast,
  output logic [15:0]       wdata,
  input  logic              bvalid,
  output logic              bready,
  output logic              arvalid,
  input  logic              arready,
  output logic [ADDR_W-1:0] araddr,
  output logic [7:0]        arlen,
  input  logic              rvalid,
  output logic              rready,
  input  logic              rlast,
  input  logic [15:0]       rdata,
  output logic              fmt_load,
  output logic [15:0]       fmt_word,
  output logic              fmt_last,
  input  logic              fmt_idle
);

  estate_t          st;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] last_idx;

  assign last_idx = IDX_W'(nwords - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ES_IDLE;
      idx <= '0;
    end else begin
      case (st)
        ES_IDLE:  if (go) begin
          st  <= is_rd ? ES_AR : ES_AW;
          idx <= '0;
        end
        ES_AW:    if (awready) st <= ES_W;
        ES_W:     if (wready) begin
          if (idx == last_idx) st <= ES_B;
          else                 idx <= idx + IDX_W'(1);
        end
        ES_B:     if (bvalid) st <= ES_FIN;
        ES_AR:    if (arready) st <= ES_R;
        ES_R:     if (rvalid && fmt_idle && rlast) st <= ES_DRAIN;
        ES_DRAIN: if (fmt_idle) st <= ES_FIN;
        ES_FIN:   st <= ES_IDLE;
        default:  st <= ES_IDLE;
      endcase
    end
  end

  assign awvalid  = (st == ES_AW);
  assign awaddr   = addr;
  assign awlen    = 8'(nwords - CNT_W'(1));
  assign wvalid   = (st == ES_W);
  assign wdata    = word;
  assign wlast    = (idx == last_idx);
  assign bready   = (st == ES_B);
  assign arvalid  = (st == ES_AR);
  assign araddr   = addr;
  assign arlen    = rdlen;
  assign rready   = (st == ES_R) && fmt_idle;
  assign fmt_load = rvalid && rready;
  assign fmt_word = rdata;
  assign fmt_last = rlast;
  assign done     = (st == ES_FIN);
  assign rd_idx   = idx;

endmodule

// File: rtl/hcab_hex_formatter.sv
module hcab_hex_formatter
  import hcab_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [4*DIGITS-1:0] word,
  input  logic               last,
  output logic               idle,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [7:0]         tx_data
);

  localparam int STEP_W = $clog2(DIGITS + 2);
  localparam logic [STEP_W-1:0] SEP_STEP = STEP_W'(DIGITS);
  localparam logic [STEP_W-1:0] LF_STEP  = STEP_W'(DIGITS + 1);

  logic                busy;
  logic [STEP_W-1:0]   step;
  logic [4*DIGITS-1:0] w_q;
  logic                last_q;
  logic [7:0]          digit_chr [DIGITS];

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    assign digit_chr[g] = nib2asc(w_q[4*(DIGITS-1-g) +: 4]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      step   <= '0;
      w_q    <= '0;
      last_q <= 1'b0;
    end else if (load && !busy) begin
      busy   <= 1'b1;
      step   <= '0;
      w_q    <= word;
      last_q <= last;
    end else if (busy && tx_ready) begin
      if ((step == SEP_STEP && !last_q) || step == LF_STEP) busy <= 1'b0;
      else                                                  step <= step + STEP_W'(1);
    end
  end

  always_comb begin
    if (step < SEP_STEP)       tx_data = digit_chr[step];
    else if (step == SEP_STEP) tx_data = last_q ? CH_CR : CH_SPACE;
    else                       tx_data = CH_LF;
  end

  assign idle     = !busy;
  assign tx_valid = busy;

endmodule

// File: rtl/hex_cmd_axi_bridge.sv
module hex_cmd_axi_bridge #(
  parameter int ADDR_W    = 26,
  parameter int MAX_WORDS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              awvalid,
  input  logic              awready,
  output logic [ADDR_W-1:0] awaddr,
  output logic [7:0]        awlen,
  output logic              wvalid,
  input  logic              wready,
  output logic              wlast,
  output logic [15:0]       wdata,
  input  logic              bvalid,
  output logic              bready,
  output logic              arvalid,
  input  logic              arready,
  output logic [ADDR_W-1:0] araddr,
  output logic [7:0]        arlen,
  input  logic              rvalid,
  output logic              rready,
  input  logic              rlast,
  input  logic [15:0]       rdata
);

  localparam int CNT_W = $clog2(MAX_WORDS + 1);
  localparam int IDX_W = $clog2(MAX_WORDS);

  logic              go, is_rd, done;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  nwords;
  logic [7:0]        rdlen;
  logic [IDX_W-1:0]  rd_idx;
  logic [15:0]       rd_word;
  logic              fmt_load, fmt_last, fmt_idle;
  logic [15:0]       fmt_word;

  hcab_line_parser #(
    .ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_parser (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .done(done), .go(go), .is_rd(is_rd), .addr(addr),
    .nwords(nwords), .rdlen(rdlen), .rd_idx(rd_idx), .rd_word(rd_word)
  );

  hcab_burst_engine #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_engine (
    .clk(clk), .rst_n(rst_n),
    .go(go), .is_rd(is_rd), .addr(addr), .nwords(nwords), .rdlen(rdlen),
    .done(done), .rd_idx(rd_idx), .word(rd_word),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen),
    .wvalid(wvalid), .wready(wready), .wlast(wlast), .wdata(wdata),
    .bvalid(bvalid), .bready(bready),
    .arvalid(arvalid), .arready(arready), .araddr(araddr), .arlen(arlen),
    .rvalid(rvalid), .rready(rready), .rlast(rlast), .rdata(rdata),
    .fmt_load(fmt_load), .fmt_word(fmt_word), .fmt_last(fmt_last),
    .fmt_idle(fmt_idle)
  );

  hcab_hex_formatter #(.DIGITS(4)) u_fmt (
    .clk(clk), .rst_n(rst_n),
    .load(fmt_load), .word(fmt_word), .last(fmt_last), .idle(fmt_idle),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );

endmodule

// File: rtl/hcab_checker.sv
module hcab_checker #(
  parameter int ADDR_W = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              awvalid,
  input logic              awready,
  input logic [ADDR_W-1:0] awaddr,
  input logic [7:0]        awlen,
  input logic              wvalid,
  input logic              wready,
  input logic              wlast,
  input logic              bready,
  input logic              arvalid,
  input logic              arready,
  input logic [ADDR_W-1:0] araddr,
  input logic [7:0]        arlen,
  input logic              rvalid,
  input logic              rready
);

  logic [7:0] beat;

  always_ff @(posedge clk) begin
    if (!rst_n)                  beat <= '0;
    else if (awvalid && awready) beat <= '0;
    else if (wvalid && wready)   beat <= beat + 8'd1;
  end

  p_wlast_pos_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && wready) |-> (wlast == (beat == awlen)));

  p_aw_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && !awready) |=> (awvalid && $stable(awaddr) && $stable(awlen)));

  p_ar_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid && !arready) |=> (arvalid && $stable(araddr) && $stable(arlen)));

  p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_rx_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid || wvalid || bready || arvalid || rready || tx_valid) |-> !rx_ready);

  p_one_channel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({awvalid, wvalid, bready, arvalid, rready}));

  p_no_rready_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rready);

  p_beat_starts_text_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && rready) |=> tx_valid);

endmodule

bind hex_cmd_axi_bridge hcab_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen),
  .wvalid(wvalid), .wready(wready), .wlast(wlast), .bready(bready),
  .arvalid(arvalid), .arready(arready), .araddr(araddr), .arlen(arlen),
  .rvalid(rvalid), .rready(rready)
);

// File: tb/tb_hex_cmd_axi_bridge.sv
module tb_hex_cmd_axi_bridge;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 26;
  localparam int SMEM       = 1024;
  localparam int WD_CYCLES  = 150000;

  logic clk, rst_n;
  logic rx_valid, rx_ready;
  logic [7:0] rx_data;
  logic tx_valid, tx_ready;
  logic [7:0] tx_data;
  logic awvalid, awready, wvalid, wready, wlast, bvalid, bready;
  logic arvalid, arready, rvalid, rready, rlast;
  logic [ADDR_W-1:0] awaddr, araddr;
  logic [7:0] awlen, arlen;
  logic [15:0] wdata, rdata;

  hex_cmd_axi_bridge #(.ADDR_W(ADDR_W), .MAX_WORDS(256)) dut (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen),
    .wvalid(wvalid), .wready(wready), .wlast(wlast), .wdata(wdata),
    .bvalid(bvalid), .bready(bready),
    .arvalid(arvalid), .arready(arready), .araddr(araddr), .arlen(arlen),
    .rvalid(rvalid), .rready(rready), .rlast(rlast), .rdata(rdata)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  int aw_seen = 0, ar_seen = 0, aw_exp_n = 0, ar_exp_n = 0;

  int unsigned exp_aw_addr[$], exp_ar_addr[$];
  int          exp_aw_len[$],  exp_ar_len[$];
  string       exp_aw_tag[$],  exp_ar_tag[$], exp_w_tag[$], exp_tx_tag[$];
  logic [15:0] exp_w[$];
  logic [7:0]  exp_tx[$];
  logic [15:0] ref_mem [SMEM];
  logic [15:0] smem    [SMEM];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pattern(input int i);
    return 16'(i * 16'h1357) ^ 16'hA5A5;
  endfunction

  initial begin
    clk = 0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // AXI slave: outputs are decided at the falling edge; handshakes land on the next rising edge
  initial begin : slave
    bit aw_act = 0, ar_act = 0, b_pend = 0, aw_wait = 0, ar_wait = 0;
    int w_base = 0, w_idx = 0, w_len = 0, r_base = 0, r_idx = 0, r_len = 0, b_dly = 0;
    logic [ADDR_W-1:0] hold_addr, hold_raddr;
    logic [7:0] hold_len, hold_rlen;
    awready = 0; wready = 0; bvalid = 0; arready = 0; rvalid = 0; rlast = 0; rdata = '0;
    for (int i = 0; i < SMEM; i++) begin
      smem[i]    = pattern(i);
      ref_mem[i] = pattern(i);
    end
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        awready = 0; wready = 0; bvalid = 0; arready = 0; rvalid = 0;
        continue;
      end
      if (aw_wait) check(awvalid && awaddr == hold_addr && awlen == hold_len,
                         "R9", "awvalid/awaddr hold", awaddr, hold_addr);
      if (ar_wait) check(arvalid && araddr == hold_raddr && arlen == hold_rlen,
                         "R9", "arvalid/araddr hold", araddr, hold_raddr);
      if (b_pend && b_dly != 0) b_dly--;
      awready = !aw_act && !b_pend && cyc[0];
      wready  = aw_act && (cyc % 3 != 2);
      bvalid  = b_pend && (b_dly == 0);
      arready = !ar_act && (cyc % 3 != 0);
      rvalid  = ar_act && (cyc % 5 != 3);
      rdata   = smem[(r_base + r_idx) % SMEM];
      rlast   = (r_idx == r_len);
      aw_wait = awvalid && !awready; hold_addr  = awaddr; hold_len  = awlen;
      ar_wait = arvalid && !arready; hold_raddr = araddr; hold_rlen = arlen;
      if (awvalid && awready) begin
        aw_seen++;
        check(rx_ready == 0, "R8", "rx_ready during AW", rx_ready, 0);
        if (exp_aw_addr.size() == 0) check(0, "R6", "unexpected AW", awaddr, 0);
        else begin
          automatic int unsigned ea = exp_aw_addr.pop_front();
          automatic int el = exp_aw_len.pop_front();
          automatic string tg = exp_aw_tag.pop_front();
          check(awaddr == ADDR_W'(ea), tg, "awaddr", awaddr, ea);
          check(awlen == 8'(el), tg, "awlen", awlen, el);
        end
        aw_act = 1; w_base = int'(awaddr >> 1); w_idx = 0; w_len = awlen;
      end
      if (wvalid && wready) begin
        if (exp_w.size() == 0) check(0, "R6", "unexpected W beat", wdata, 0);
        else begin
          automatic logic [15:0] ew = exp_w.pop_front();
          automatic string tg = exp_w_tag.pop_front();
          check(wdata == ew, tg, "wdata", wdata, ew);
        end
        check(wlast == (w_idx == w_len), "R1", "wlast position", wlast, w_idx == w_len);
        smem[(w_base + w_idx) % SMEM] = wdata;
        if (w_idx == w_len) begin
          aw_act = 0; b_pend = 1; b_dly = 4;
        end else w_idx++;
      end
      if (bvalid && bready) begin
        check(rx_ready == 0, "R8", "rx_ready until B", rx_ready, 0);
        b_pend = 0;
      end
      if (arvalid && arready) begin
        ar_seen++;
        if (exp_ar_addr.size() == 0) check(0, "R6", "unexpected AR", araddr, 0);
        else begin
          automatic int unsigned ea = exp_ar_addr.pop_front();
          automatic int el = exp_ar_len.pop_front();
          automatic string tg = exp_ar_tag.pop_front();
          check(araddr == ADDR_W'(ea), tg, "araddr", araddr, ea);
          check(arlen == 8'(el), "R2", "arlen", arlen, el);
        end
        ar_act = 1; r_base = int'(araddr >> 1); r_idx = 0; r_len = arlen;
      end
      if (rvalid && rready) begin
        check(tx_valid == 0, "R11", "rready with text pending", tx_valid, 0);
        check(rx_ready == 0, "R8", "rx_ready during R", rx_ready, 0);
        if (r_idx == r_len) ar_act = 0;
        else r_idx++;
      end
    end
  end

  // text sink / scoreboard monitor
  initial begin : sink
    bit tx_wait = 0;
    logic [7:0] hold_d = '0;
    tx_ready = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin tx_ready = 0; continue; end
      if (tx_wait) check(tx_valid && tx_data == hold_d, "R9", "tx hold", tx_data, hold_d);
      tx_ready = (cyc % 4 != 1);
      tx_wait  = tx_valid && !tx_ready;
      hold_d   = tx_data;
      if (tx_valid && tx_ready) begin
        if (exp_tx.size() == 0) check(0, "R4", "unexpected tx byte", tx_data, 0);
        else begin
          automatic logic [7:0] eb = exp_tx.pop_front();
          automatic string tg = exp_tx_tag.pop_front();
          check(tx_data == eb, tg, "tx byte", tx_data, eb);
        end
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    rx_valid = 1; rx_data = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_byte(s[i]);
  endtask

  task automatic write_line(input string line, input int unsigned addr,
                            input logic [15:0] ws[$], input string tag);
    exp_aw_addr.push_back(addr); exp_aw_len.push_back(ws.size() - 1);
    exp_aw_tag.push_back(tag); aw_exp_n++;
    foreach (ws[k]) begin
      exp_w.push_back(ws[k]); exp_w_tag.push_back(tag);
      ref_mem[(int'(addr >> 1) + k) % SMEM] = ws[k];
    end
    send_str(line);
  endtask

  task automatic do_write(input int unsigned addr, input logic [15:0] ws[$], input string tag);
    string s;
    s = $sformatf("w%0h", addr);
    foreach (ws[k]) s = {s, $sformatf(" %04h", ws[k])};
    s = {s, "\r"};
    write_line(s, addr, ws, tag);
  endtask

  task automatic read_line(input string line, input int unsigned addr, input int len,
                           input string tag);
    exp_ar_addr.push_back(addr); exp_ar_len.push_back(len);
    exp_ar_tag.push_back(tag); ar_exp_n++;
    for (int k = 0; k <= len; k++) begin
      automatic string h = $sformatf("%04h", ref_mem[(int'(addr >> 1) + k) % SMEM]);
      for (int c = 0; c < 4; c++) begin exp_tx.push_back(h[c]); exp_tx_tag.push_back(tag); end
      if (k == len) begin
        exp_tx.push_back(8'h0D); exp_tx_tag.push_back("R4");
        exp_tx.push_back(8'h0A); exp_tx_tag.push_back("R4");
      end else begin
        exp_tx.push_back(8'h20); exp_tx_tag.push_back("R4");
      end
    end
    send_str(line);
  endtask

  task automatic do_read(input int unsigned addr, input int len, input string tag);
    read_line($sformatf("r%0h %0h\r", addr, len), addr, len, tag);
  endtask

  initial begin : main
    logic [15:0] ws[$];
    rx_valid = 0; rx_data = '0; rst_n = 0;
    repeat (3) @(negedge clk);
    check(rx_ready == 1, "R10", "rx_ready in reset", rx_ready, 1);
    check(!tx_valid && !awvalid && !wvalid && !arvalid, "R10", "valids in reset",
          {tx_valid, awvalid, wvalid, arvalid}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check(rx_ready == 1 && !tx_valid && !awvalid && !arvalid, "R10", "after reset",
          {rx_ready, tx_valid, awvalid, arvalid}, 8);

    // R1 basic write, R2/R4 read back with untouched tail
    ws = '{16'h0123, 16'h4567, 16'h89ab, 16'hcdef};
    do_write(32'h12345, ws, "R1");
    do_read(32'h12345, 7, "R2");
    // R1 ten-word write at address 0, R2 read of 31 words ("1e") ending CR LF
    ws = '{16'h1234, 16'h2345, 16'h3456, 16'h4567, 16'h5678,
           16'h6789, 16'h789a, 16'h89ab, 16'h9abc, 16'habcd};
    do_write(0, ws, "R1");
    read_line("r0 1e\r\n", 0, 30, "R4");
    // R5 uppercase digits and repeated spaces
    ws = '{16'hbeef, 16'hc0de};
    write_line("wA0  BEEF   C0DE\n", 32'ha0, ws, "R5");
    read_line("rA0 1\r", 32'ha0, 1, "R5");
    // R3 short fields are zero-extended
    ws = '{16'h0007, 16'h00ab};
    write_line("w10 7 ab\r", 32'h10, ws, "R3");
    do_read(32'h10, 1, "R3");
    // R6 malformed lines leave memory untouched
    send_str("w20 12x4 5555\r");
    send_str("q1 2\r");
    send_str("w30\r");
    send_str("r40 1 2\r");
    send_str("\r\n");
    do_read(32'h20, 1, "R6");
    do_read(32'h30, 0, "R6");
    // R7 full 256-word burst, then a 257-word line that is dropped
    ws.delete();
    for (int i = 0; i < 256; i++) ws.push_back(16'(i) ^ 16'h5a00);
    do_write(32'h200, ws, "R7");
    do_read(32'h3fc, 1, "R7");
    begin
      string s = "w600";
      for (int i = 0; i < 257; i++) s = {s, " 1111"};
      send_str({s, "\r"});
    end
    do_read(32'h600, 3, "R7");

    while (exp_tx.size() != 0 || !rx_ready) @(negedge clk);
    repeat (20) @(negedge clk);
    check(aw_seen == aw_exp_n, "R6", "write burst count", aw_seen, aw_exp_n);
    check(ar_seen == ar_exp_n, "R6", "read burst count", ar_seen, ar_exp_n);
    check(exp_w.size() == 0, "R1", "pending W beats", exp_w.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d expected < %0d cycles", WD_CYCLES, WD_CYCLES);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule